// File: doc/BRIEF.md
# Parallel Mixed-Length Instruction Boundary Finder

This block sits between instruction fetch and decode. Each cycle it takes one aligned fetch window of 16-bit parcels and works out which parcels begin an instruction. Instructions are either one parcel (16 bits) or two parcels (32 bits). The length is known from the two lowest bits of the first parcel alone. The block then packs the instructions it found into dense output slots in program order. Each slot carries the assembled instruction word, a 32-bit flag, an illegal flag and the byte offset of the instruction within the window.

A 32-bit instruction that starts on the last parcel of a window cannot finish in that window. The block keeps that parcel and a carry bit. It joins the parcel with parcel 0 of the next accepted window and emits the pair as slot 0 of that window. The start positions of a whole window are resolved in one cycle by a logarithmic prefix over per-parcel transfer functions, not by a serial walk. A valid/ready handshake sits on both sides. A flush input drops the pending output and the carry state when fetch is redirected.

Top module: `parcel_boundary_finder`

## Requirements
- R1: A parcel whose bits [1:0] equal 2'b11 begins a 32-bit instruction made of itself (low half) and the following parcel (high half). Any other value of bits [1:0] begins a 16-bit instruction, which is reported zero-extended in the 32-bit slot word.
- R2: Instructions are reported in program order in slots 0 to count-1. A slot's offset field gives the byte offset (2 × parcel index) of the instruction's first parcel. No parcel that is the high half of a 32-bit instruction is reported as a start.
- R3: While the carry is set, slot 0 of the next accepted window holds {that window's parcel 0, held parcel}, with the 32-bit flag set and offset 0. Decoding then continues at parcel 1.
- R4: If the last parcel of a window begins a 32-bit instruction, it is not emitted in that window. carry_out goes to 1 together with that window's output, and the parcel is held for the next window.
- R5: A 32-bit start whose bits [4:2] are 3'b111 (a reserved longer encoding) still takes exactly two parcels, and its slot's illegal flag is 1. Illegal flags are 0 on 16-bit slots.
- R6: A valid output's count lies between NPARC/2 and NPARC (4 to 8 with the defaults).
- R7: While out_valid is 1 and out_ready is 0, in_ready is 0. The output fields and carry_out stay unchanged, and no input is accepted.
- R8: A flush clears out_valid and carry_out on the next edge and accepts no input in that cycle. The next accepted window is decoded from parcel 0.
- R9: After reset, out_valid and carry_out are 0 and in_ready is 1.
- R10: Slot fields at index count and above (instruction word, flags, offset) are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Redirect: drops pending output and carry state |
| in_valid | input | 1 | Fetch window present |
| in_ready | output | 1 | Window accepted on this edge when in_valid is also high |
| in_data | input | NPARC*16 | Fetch window, parcel i at bits [16i+15:16i] |
| out_valid | output | 1 | Slot outputs hold a decoded window |
| out_ready | input | 1 | Consumer takes the slots |
| out_count | output | CNT_W | Number of valid slots |
| out_instr | output | NPARC*32 | Slot words, slot k at bits [32k+31:32k] |
| out_is32 | output | NPARC | Per-slot 32-bit flag |
| out_illegal | output | NPARC | Per-slot reserved-encoding flag |
| out_offset | output | NPARC*OFF_W | Per-slot byte offset within the window |
| carry_out | output | 1 | A 32-bit instruction spills into the next window |

## Verification
On every cycle the assertions check the handshake stall (R7), the effect of a flush on the next edge (R8), the count range (R6), that unused slots are zero (R10), that illegal flags appear only on 32-bit slots (R5), and that no high-half parcel is ever marked as a start (R2). Only the bench scenarios can show that the packed words, offsets and carry follow the length rule over a chain of windows. Those scenarios cover spills into the next window, a reserved encoding that straddles windows, and a clean restart after a flush (R1, R3, R4, R8).

// File: rtl/pbf_pkg.sv
package pbf_pkg;
  localparam int PARCEL_W = 16;
  localparam int WORD_W   = 32;

  // two low bits set: instruction spans two parcels
  function automatic logic is_long(input logic [PARCEL_W-1:0] p);
    return p[1:0] == 2'b11;
  endfunction

  // long encoding with bits 4:2 all ones: reserved for longer formats
  function automatic logic is_reserved(input logic [PARCEL_W-1:0] p);
    return p[4:0] == 5'b11111;
  endfunction
endpackage

// File: rtl/pbf_start_prefix.sv
// Start marks via a log-depth prefix of 1-bit transfer functions.
// f_i(s) = next-start given parcel i's start state s: f(0)=1, f(1)=~long.
module pbf_start_prefix #(
  parameter int N = 8,
  localparam int LV = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] long_i,
  input  logic         first_start_i,
  output logic [N-1:0] start_o
);
  // fn[l][i][x] = composed map over parcels (i-2^l+1 .. i) applied to x
  logic [1:0] fn [LV+1][N];

  for (genvar i = 0; i < N; i++) begin : g_leaf
    assign fn[0][i] = {~long_i[i], 1'b1};
  end

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    for (genvar i = 0; i < N; i++) begin : g_node
      if (i >= (1 << l)) begin : g_cmp
        logic [1:0] inner;
        logic [1:0] outer;
        assign inner = fn[l][i-(1<<l)];
        assign outer = fn[l][i];
        assign fn[l+1][i] = {outer[inner[1]], outer[inner[0]]};
      end else begin : g_pass
        assign fn[l+1][i] = fn[l][i];
      end
    end
  end

  assign start_o[0] = first_start_i;
  for (genvar i = 1; i < N; i++) begin : g_out
    assign start_o[i] = fn[LV][i-1][first_start_i];
  end
endmodule

// File: rtl/pbf_slot_pack.sv
// Packs the marked starts densely into slots, handles straddle in/out.
module pbf_slot_pack
  import pbf_pkg::*;
#(
  parameter int N = 8,
  parameter int OFF_W = 4,
  parameter int CNT_W = 4
) (
  input  logic [N*PARCEL_W-1:0] parcels_i,
  input  logic [PARCEL_W-1:0]   held_i,
  input  logic                  carry_i,
  input  logic [N-1:0]          start_i,
  output logic [CNT_W-1:0]      count_o,
  output logic [N*WORD_W-1:0]   instr_o,
  output logic [N-1:0]          is32_o,
  output logic [N-1:0]          illegal_o,
  output logic [N*OFF_W-1:0]    offset_o,
  output logic                  carry_next_o,
  output logic [PARCEL_W-1:0]   held_next_o
);
  logic [(N+1)*PARCEL_W-1:0] padded;
  assign padded = {{PARCEL_W{1'b0}}, parcels_i};

  always_comb begin
    int run;
    logic [PARCEL_W-1:0] p;
    logic [PARCEL_W-1:0] hi;
    run          = 0;
    instr_o      = '0;
    is32_o       = '0;
    illegal_o    = '0;
    offset_o     = '0;
    carry_next_o = 1'b0;
    held_next_o  = '0;
    for (int i = 0; i < N; i++) begin
      p  = padded[PARCEL_W*i +: PARCEL_W];
      hi = padded[PARCEL_W*(i+1) +: PARCEL_W];
      if (i == 0 && carry_i) begin
        instr_o[0 +: WORD_W] = {p, held_i};
        is32_o[0]            = 1'b1;
        illegal_o[0]         = is_reserved(held_i);
        run                  = 1;
      end else if (start_i[i]) begin
        if (is_long(p) && i == N-1) begin
          carry_next_o = 1'b1;
          held_next_o  = p;
        end else if (is_long(p)) begin
          instr_o[run*WORD_W +: WORD_W] = {hi, p};
          is32_o[run]                   = 1'b1;
          illegal_o[run]                = is_reserved(p);
          offset_o[run*OFF_W +: OFF_W]  = OFF_W'(2*i);
          run++;
        end else begin
          instr_o[run*WORD_W +: WORD_W] = {{PARCEL_W{1'b0}}, p};
          offset_o[run*OFF_W +: OFF_W]  = OFF_W'(2*i);
          run++;
        end
      end
    end
    count_o = CNT_W'(run);
  end
endmodule

// File: rtl/parcel_boundary_finder.sv
module parcel_boundary_finder
  import pbf_pkg::*;
#(
  parameter int NPARC = 8,
  localparam int OFF_W = $clog2(2*NPARC),
  localparam int CNT_W = $clog2(NPARC+1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [NPARC*16-1:0]      in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [CNT_W-1:0]         out_count,
  output logic [NPARC*32-1:0]      out_instr,
  output logic [NPARC-1:0]         out_is32,
  output logic [NPARC-1:0]         out_illegal,
  output logic [NPARC*OFF_W-1:0]   out_offset,
  output logic                     carry_out
);
  logic [PARCEL_W-1:0] held_q;
  logic [NPARC-1:0]    long_w, start_w;
  logic [CNT_W-1:0]    cnt_w;
  logic [NPARC*WORD_W-1:0] instr_w;
  logic [NPARC-1:0]    is32_w, ill_w;
  logic [NPARC*OFF_W-1:0] off_w;
  logic                carry_nx;
  logic [PARCEL_W-1:0] held_nx;
  logic                accept;

  for (genvar i = 0; i < NPARC; i++) begin : g_len
    assign long_w[i] = is_long(in_data[PARCEL_W*i +: PARCEL_W]);
  end

  pbf_start_prefix #(.N(NPARC)) u_prefix (
    .long_i(long_w), .first_start_i(~carry_out), .start_o(start_w)
  );

  pbf_slot_pack #(.N(NPARC), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_pack (
    .parcels_i(in_data), .held_i(held_q), .carry_i(carry_out),
    .start_i(start_w), .count_o(cnt_w), .instr_o(instr_w),
    .is32_o(is32_w), .illegal_o(ill_w), .offset_o(off_w),
    .carry_next_o(carry_nx), .held_next_o(held_nx)
  );

  assign in_ready = (~out_valid | out_ready) & ~flush;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_count   <= '0;
      out_instr   <= '0;
      out_is32    <= '0;
      out_illegal <= '0;
      out_offset  <= '0;
      carry_out   <= 1'b0;
      held_q      <= '0;
    end else if (flush) begin
      out_valid <= 1'b0;
      carry_out <= 1'b0;
      held_q    <= '0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_count   <= cnt_w;
      out_instr   <= instr_w;
      out_is32    <= is32_w;
      out_illegal <= ill_w;
      out_offset  <= off_w;
      carry_out   <= carry_nx;
      held_q      <= held_nx;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7: stalled output is frozen and input is refused
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready && !flush |=> out_valid && $stable(out_count)
      && $stable(out_instr) && $stable(out_offset) && $stable(carry_out));
  assert_stall_refuse_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);
  // R8: flush empties output and carry
  assert_flush_clear_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_valid && !carry_out);
  // R6: count range
  assert_count_range_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_count >= CNT_W'(NPARC/2) && out_count <= CNT_W'(NPARC));
  // R10: slots past count are empty
  assert_unused_zero_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_is32 >> out_count) == '0 && (out_illegal >> out_count) == '0);
  // R5: illegal only on 32-bit slots
  assert_illegal_long_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_illegal & ~out_is32) == '0);
  // R2: the high half of a long instruction is never a start
  for (genvar i = 0; i < NPARC-1; i++) begin : g_chk
    assert_skip_upper_R2: assert property (@(posedge clk) disable iff (rst)
      start_w[i] && long_w[i] |-> !start_w[i+1]);
  end
endmodule

// File: tb/test_parcel_boundary_finder.sv
module test_parcel_boundary_finder;
  localparam int N = 8;
  localparam int OW = 4;
  localparam int CW = 4;
  localparam int NV = 7;
  localparam logic [127:0] VEC [NV] = '{
    {16'h1009,16'h1008,16'h1006,16'h1005,16'h1004,16'h1002,16'h1001,16'h1000},
    {16'hA004,16'h2043,16'hA003,16'h2023,16'hA002,16'h2013,16'hA001,16'h2003},
    {16'h30A3,16'h3001,16'h6666,16'h3013,16'h3002,16'h5555,16'h3003,16'h3000},
    {16'h4005,16'h4004,16'h4002,16'h4001,16'h4000,16'h8888,16'h401F,16'h7777},
    {16'h509F,16'hB003,16'h5023,16'hB002,16'h5013,16'hB001,16'h5003,16'h5000},
    {16'h6033,16'hC003,16'h6023,16'hC002,16'h6013,16'hC001,16'h6003,16'hC000},
    {16'h7008,16'h7006,16'h7005,16'h7004,16'h7002,16'h7001,16'h7000,16'hD000}
  };

  logic clk = 0, rst = 1, flush = 0, in_valid = 0, out_ready = 0;
  logic [N*16-1:0] in_data = '0;
  logic in_ready, out_valid, carry_out;
  logic [CW-1:0] out_count;
  logic [N*32-1:0] out_instr;
  logic [N-1:0] out_is32, out_illegal;
  logic [N*OW-1:0] out_offset;

  parcel_boundary_finder #(.NPARC(N)) i_parcel_boundary_finder (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_count(out_count), .out_instr(out_instr),
    .out_is32(out_is32), .out_illegal(out_illegal),
    .out_offset(out_offset), .carry_out(carry_out)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic m_carry = 0;
  logic [15:0] m_held = '0;
  logic [N*32-1:0] e_instr;
  logic [N-1:0] e_is32, e_ill;
  logic [N*OW-1:0] e_off;
  int e_cnt;

  task automatic chk(input bit ok, input string msg,
                     input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", msg, act, exp);
    end
  endtask

  // serial reference walk over the window
  task automatic model(input logic [127:0] w);
    int pos, n;
    logic [15:0] p;
    e_instr = '0; e_is32 = '0; e_ill = '0; e_off = '0;
    n = 0; pos = 0;
    if (m_carry) begin
      e_instr[31:0] = {w[15:0], m_held};
      e_is32[0] = 1'b1;
      e_ill[0] = (m_held[4:0] == 5'h1F);
      n = 1; pos = 1;
    end
    m_carry = 1'b0; m_held = '0;
    while (pos < N) begin
      p = w[pos*16 +: 16];
      if (p[1:0] != 2'b11) begin
        e_instr[n*32 +: 32] = {16'h0, p};
        e_off[n*OW +: OW] = OW'(pos*2);
        n++; pos++;
      end else if (pos == N-1) begin
        m_carry = 1'b1; m_held = p; pos = N;
      end else begin
        e_instr[n*32 +: 32] = {w[(pos+1)*16 +: 16], p};
        e_is32[n] = 1'b1;
        e_ill[n] = (p[4:2] == 3'b111);
        e_off[n*OW +: OW] = OW'(pos*2);
        n++; pos += 2;
      end
    end
    e_cnt = n;
  endtask

  task automatic check_win(input string tag);
    chk(out_valid == 1'b1 && out_count == CW'(e_cnt),
        {tag, " R6 valid/count"}, 256'(out_count), 256'(e_cnt));
    chk(out_instr == e_instr, {tag, " R1 R2 R10 slot words"}, out_instr, e_instr);
    chk(out_is32 == e_is32 && out_illegal == e_ill && out_offset == e_off,
        {tag, " R2 R5 flags/offsets"},
        256'({out_is32, out_illegal, out_offset}), 256'({e_is32, e_ill, e_off}));
    chk(carry_out == m_carry, {tag, " R4 carry_out"}, 256'(carry_out), 256'(m_carry));
  endtask

  task automatic send(input logic [127:0] w);
    @(negedge clk);
    in_valid = 1; in_data = w; out_ready = 1;
    model(w);
    @(negedge clk);
    in_valid = 0;
  endtask

  bit done = 0;
  initial begin
    #(4*200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    chk(out_valid == 0 && carry_out == 0 && in_ready == 1, "R9 reset state",
        256'({out_valid, carry_out, in_ready}), 256'(3'b001));

    // vector table walk, carry chains across windows (R1 R2 R3 R4 R5 R6 R10)
    for (int v = 0; v < NV; v++) begin
      send(VEC[v]);
      check_win($sformatf("vec%0d R3", v));
    end

    // drain
    @(negedge clk); out_ready = 1; in_valid = 0;
    @(negedge clk);

    // R7 backpressure
    in_valid = 1; in_data = VEC[2]; out_ready = 0;
    model(VEC[2]);
    @(negedge clk);
    check_win("R7 first");
    in_data = VEC[3];
    chk(in_ready == 0, "R7 in_ready low while stalled", 256'(in_ready), 256'(0));
    repeat (3) @(negedge clk);
    check_win("R7 held");
    chk(in_ready == 0, "R7 still refused", 256'(in_ready), 256'(0));
    out_ready = 1;
    model(VEC[3]);
    @(negedge clk);
    in_valid = 0;
    check_win("R7 R3 resumed");

    // R8 flush
    send(VEC[4]);
    check_win("R8 pre-flush");
    flush = 1; in_valid = 1; in_data = VEC[5];
    @(negedge clk);
    flush = 0; in_valid = 0;
    chk(out_valid == 0 && carry_out == 0, "R8 flush cleared",
        256'({out_valid, carry_out}), 256'(0));
    m_carry = 0; m_held = '0;
    send(VEC[3]);
    check_win("R8 clean restart");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule